// File: doc/BRIEF.md
# NAND Page Hamming ECC Engine

The engine sits beside a NAND flash data bus and watches every strobed data beat of a page transfer. While the page data area goes by it builds a 32-bit single-error-correcting, double-error-detecting Hamming code over the whole page in one pass. The code has two 16-bit halves. One half is the direct parity word. The other half is the complementary parity word. In program mode, software reads the two halves once the last data beat has passed and stores them as four bytes in the spare area.

In check mode, the four stored bytes must follow the page data directly on the bus. The engine XORs them with its own code and classifies the result as one of four cases: no error, a single data-bit error with its word and bit location, a single error inside the stored code, or an uncorrectable multiple error. It does not correct the data itself. Correcting the data, sequencing NAND commands and moving data by DMA are left to other blocks.

A sequencer with three states controls the engine:
- `SQ_DATA` accumulates parity over the page data.
- `SQ_ECC` collects the stored code beats.
- `SQ_DONE` freezes all results.

The transitions are:
- `SQ_DATA -> SQ_ECC` on the last data beat in check mode.
- `SQ_DATA -> SQ_DONE` on the last data beat in program mode.
- `SQ_ECC -> SQ_DONE` on the last code beat.
- Any state goes back to `SQ_DATA` on a restart.

Top module: `nand_ecc_engine`

## Requirements
- R1: Mode register (address 0) field [1:0] selects the page data size: 0 = 512, 1 = 1024, 2 = 2048, 3 = 4096 bytes (528 to 4224 bytes with spare). Bit [2] set selects a 16-bit bus (word = 16 bits), clear selects an 8-bit bus (word = byte). Bit [3] set selects check mode, clear selects program mode. The register reads back as written and is 0 after reset.
- R2: Each data bit has a 16-bit position code {word address[11:0], bit offset[3:0]}. Bit k of the direct parity word P is the XOR of all page data bits whose code has bit k set. Bit k of the complementary word N is the XOR of all page data bits whose code has bit k clear. On an 8-bit bus, bus bits [15:8] are ignored.
- R3: In program mode, the status done bit is set after the last data beat. Address 2 then reads P and address 3 reads N, and no error flag is set.
- R4: In check mode, the stored code follows the data directly. On an 8-bit bus it arrives as four bytes in the order P[7:0], P[15:8], N[7:0], N[15:8]. On a 16-bit bus it arrives as two words in the order P, N. Done is clear until the last code beat and is set after it.
- R5: After a check with no difference between the computed and stored code, all flags are 0 and address 2 reads 0.
- R6: A single flipped data bit sets only the error flag. Address 2 then reads {word address, bit offset} of that bit, with words counted in bus-width units.
- R7: A single flipped bit in the stored code sets the error flag and the code-error flag.
- R8: Any other difference sets the error flag and the multiple flag, and address 2 reads the direct syndrome. An erased page (all 0xFF data and all 0xFF stored code) therefore reads 0xFFFF.
- R9: A write to address 1 with bit 0 set, or any write to the mode register, restarts the engine. The restart clears the parity, the beat counter, the flags and done.
- R10: Status at address 1 is laid out as [0] error, [1] code-error, [2] multiple, [3] done. The code-error and multiple flags are never both set, and neither is set without the error flag.
- R11: Once done is set, further strobes change neither the parity nor the status until a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_strobe | input | 1 | Data beat valid on the NAND bus |
| bus_data | input | 16 | NAND bus data (bits [15:8] used on a 16-bit bus only) |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data, combinational on cfg_addr |

## Verification
The bound checker watches several properties on every cycle:
- the beat counter stays inside the selected page;
- done and the accumulated parity stay frozen after completion;
- a restart clears parity, flags and done on the next cycle;
- the flags keep their exclusivity;
- a flag never appears outside `SQ_DONE` or in program mode.

The values of the code and the classification can only be shown by the directed scenarios. These include program-mode parity at several page sizes and on both bus widths, clean pages, data and code bit flips, a double error, an erased page, and the exact beat on which done rises.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    typedef enum logic [1:0] {
        SQ_DATA = 2'd0,
        SQ_ECC  = 2'd1,
        SQ_DONE = 2'd2
    } sq_state_t;

    typedef struct packed {
        logic multi;
        logic ponly;
        logic err;
    } ecc_flags_t;

    localparam logic [1:0] RA_MODE = 2'd0;
    localparam logic [1:0] RA_CTRL = 2'd1;
    localparam logic [1:0] RA_PARP = 2'd2;
    localparam logic [1:0] RA_PARN = 2'd3;

    localparam int MODE_W = 4;

endpackage

// File: rtl/nand_ecc_cfg.sv
module nand_ecc_cfg
    import nand_ecc_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_addr,
    input  logic [REG_W-1:0]    cfg_wdata,
    output logic [MODE_W-1:0]   mode_bits,
    output logic [1:0]          size_sel,
    output logic                wide,
    output logic                check,
    output logic                restart
);

    logic [MODE_W-1:0] mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (cfg_we && (cfg_addr == RA_MODE)) begin
            mode_q <= cfg_wdata[MODE_W-1:0];
        end
    end

    always_comb begin
        mode_bits = mode_q;
        size_sel  = mode_q[1:0];
        wide      = mode_q[2];
        check     = mode_q[3];
        restart   = cfg_we && ((cfg_addr == RA_MODE) ||
                               ((cfg_addr == RA_CTRL) && cfg_wdata[0]));
    end

endmodule

// File: rtl/nand_ecc_seq.sv
module nand_ecc_seq
    import nand_ecc_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int CNT_W      = 12,
    parameter int BASE_BYTES = 512,
    parameter int CODE_W     = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  restart,
    input  logic                  strobe,
    input  logic [DATA_W-1:0]     data,
    input  logic                  wide,
    input  logic                  check,
    input  logic [1:0]            size_sel,
    output sq_state_t             state,
    output logic [CNT_W-1:0]      word_addr,
    output logic [CNT_W-1:0]      word_lim,
    output logic                  acc_en,
    output logic                  fire,
    output logic [2*CODE_W-1:0]   stored_next
);

    localparam int STORE_W = 2 * CODE_W;

    sq_state_t           state_q;
    sq_state_t           state_nx;
    logic [CNT_W-1:0]    cnt_q;
    logic [1:0]          ecc_idx_q;
    logic [1:0]          ecc_lim;
    logic [STORE_W-1:0]  stored_q;
    logic [CNT_W:0]      page_bytes;
    logic [CNT_W:0]      page_words;
    logic                ecc_we;
    logic                data_last;

    // page geometry
    always_comb begin
        page_bytes = (CNT_W+1)'(BASE_BYTES) << size_sel;
        page_words = wide ? (page_bytes >> 1) : page_bytes;
        word_lim   = CNT_W'(page_words - (CNT_W+1)'(1));
        ecc_lim    = wide ? 2'd1 : 2'd3;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_DATA;
        end else if (restart) begin
            state_q <= SQ_DATA;
        end else begin
            state_q <= state_nx;
        end
    end

    // outputs of the sequencer
    always_comb begin
        acc_en    = 1'b0;
        ecc_we    = 1'b0;
        unique case (state_q)
            SQ_DATA: acc_en = strobe;
            SQ_ECC:  ecc_we = strobe;
            SQ_DONE: ;
            default: ;
        endcase
        data_last = acc_en && (cnt_q == word_lim);
        fire      = ecc_we && (ecc_idx_q == ecc_lim);
        state     = state_q;
        word_addr = cnt_q;
    end

    // next-state decode
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            SQ_DATA: if (data_last) state_nx = check ? SQ_ECC : SQ_DONE;
            SQ_ECC:  if (fire)      state_nx = SQ_DONE;
            SQ_DONE: state_nx = SQ_DONE;
            default: state_nx = SQ_DATA;
        endcase
    end

    // beat counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            ecc_idx_q <= '0;
        end else if (restart) begin
            cnt_q     <= '0;
            ecc_idx_q <= '0;
        end else begin
            if (acc_en && !data_last) cnt_q <= cnt_q + 1'b1;
            if (ecc_we && !fire)      ecc_idx_q <= ecc_idx_q + 1'b1;
        end
    end

    // stored code assembly, low lane first
    always_comb begin
        stored_next = stored_q;
        if (ecc_we) begin
            if (wide) stored_next[{ecc_idx_q[0], 4'b0000} +: 16] = data[15:0];
            else      stored_next[{ecc_idx_q, 3'b000} +: 8]      = data[7:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stored_q <= '0;
        end else if (restart) begin
            stored_q <= '0;
        end else if (ecc_we) begin
            stored_q <= stored_next;
        end
    end

endmodule

// File: rtl/nand_ecc_accum.sv
module nand_ecc_accum #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12,
    parameter int BIT_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      en,
    input  logic                      wide,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         data,
    output logic [ADDR_W+BIT_W-1:0]   par_p,
    output logic [ADDR_W+BIT_W-1:0]   par_n
);

    localparam int CODE_W = ADDR_W + BIT_W;

    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] dm;
    logic [BIT_W-1:0]  bp;
    logic [BIT_W-1:0]  bn;
    logic [ADDR_W-1:0] ap;
    logic [ADDR_W-1:0] an;
    logic              word_par;
    logic [CODE_W-1:0] p_q;
    logic [CODE_W-1:0] n_q;

    always_comb begin
        lane_mask = wide ? {DATA_W{1'b1}} : {{(DATA_W-8){1'b0}}, 8'hFF};
        dm        = data & lane_mask;
        word_par  = ^dm;
        bp        = '0;
        bn        = '0;
        for (int k = 0; k < BIT_W; k++) begin
            for (int j = 0; j < DATA_W; j++) begin
                if (j[k]) bp[k] = bp[k] ^ dm[j];
                else      bn[k] = bn[k] ^ dm[j];
            end
        end
    end

    // line parities: a whole word lands on one side of each address bit
    for (genvar a = 0; a < ADDR_W; a++) begin : g_line
        assign ap[a] = addr[a]  & word_par;
        assign an[a] = !addr[a] & word_par;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
            n_q <= '0;
        end else if (clear) begin
            p_q <= '0;
            n_q <= '0;
        end else if (en) begin
            p_q <= p_q ^ {ap, bp};
            n_q <= n_q ^ {an, bn};
        end
    end

    assign par_p = p_q;
    assign par_n = n_q;

endmodule

// File: rtl/nand_ecc_judge.sv
module nand_ecc_judge
    import nand_ecc_pkg::*;
#(
    parameter int CODE_W = 16
) (
    input  logic [CODE_W-1:0] calc_p,
    input  logic [CODE_W-1:0] calc_n,
    input  logic [CODE_W-1:0] stored_p,
    input  logic [CODE_W-1:0] stored_n,
    output ecc_flags_t        flags,
    output logic [CODE_W-1:0] syn_p,
    output logic [CODE_W-1:0] syn_n
);

    logic [2*CODE_W-1:0]      syn_all;
    logic [$clog2(2*CODE_W):0] ones;

    always_comb begin
        syn_p   = calc_p ^ stored_p;
        syn_n   = calc_n ^ stored_n;
        syn_all = {syn_n, syn_p};
        ones    = ($clog2(2*CODE_W)+1)'($countones(syn_all));
        flags   = '0;
        if (syn_all == '0) begin
            flags = '0;
        end else if (ones == 1) begin
            flags.err   = 1'b1;
            flags.ponly = 1'b1;
        end else if ((syn_p ^ syn_n) == {CODE_W{1'b1}}) begin
            flags.err   = 1'b1;
        end else begin
            flags.err   = 1'b1;
            flags.multi = 1'b1;
        end
    end

endmodule

// File: rtl/nand_ecc_engine.sv
module nand_ecc_engine
    import nand_ecc_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 12,
    parameter int BIT_W      = 4,
    parameter int BASE_BYTES = 512,
    parameter int REG_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_strobe,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata
);

    localparam int CODE_W = ADDR_W + BIT_W;

    logic [MODE_W-1:0]   mode_bits;
    logic [1:0]          size_sel;
    logic                mode_wide;
    logic                mode_check;
    logic                restart;
    sq_state_t           state;
    logic [ADDR_W-1:0]   word_addr;
    logic [ADDR_W-1:0]   word_lim;
    logic                acc_en;
    logic                fire;
    logic [2*CODE_W-1:0] stored_next;
    logic [CODE_W-1:0]   acc_p;
    logic [CODE_W-1:0]   acc_n;
    ecc_flags_t          judge_flags;
    logic [CODE_W-1:0]   syn_p;
    logic [CODE_W-1:0]   syn_n;
    ecc_flags_t          flags_q;
    logic [CODE_W-1:0]   res_p;
    logic [CODE_W-1:0]   res_n;
    logic                st_done;
    logic                show_res;

    nand_ecc_cfg #(.REG_W(REG_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .mode_bits (mode_bits),
        .size_sel  (size_sel),
        .wide      (mode_wide),
        .check     (mode_check),
        .restart   (restart)
    );

    nand_ecc_seq #(
        .DATA_W     (DATA_W),
        .CNT_W      (ADDR_W),
        .BASE_BYTES (BASE_BYTES),
        .CODE_W     (CODE_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .strobe      (bus_strobe),
        .data        (bus_data),
        .wide        (mode_wide),
        .check       (mode_check),
        .size_sel    (size_sel),
        .state       (state),
        .word_addr   (word_addr),
        .word_lim    (word_lim),
        .acc_en      (acc_en),
        .fire        (fire),
        .stored_next (stored_next)
    );

    nand_ecc_accum #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .BIT_W  (BIT_W)
    ) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (restart),
        .en    (acc_en),
        .wide  (mode_wide),
        .addr  (word_addr),
        .data  (bus_data),
        .par_p (acc_p),
        .par_n (acc_n)
    );

    nand_ecc_judge #(.CODE_W(CODE_W)) u_judge (
        .calc_p   (acc_p),
        .calc_n   (acc_n),
        .stored_p (stored_next[CODE_W-1:0]),
        .stored_n (stored_next[2*CODE_W-1:CODE_W]),
        .flags    (judge_flags),
        .syn_p    (syn_p),
        .syn_n    (syn_n)
    );

    // verdict latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            res_p   <= '0;
            res_n   <= '0;
        end else if (restart) begin
            flags_q <= '0;
            res_p   <= '0;
            res_n   <= '0;
        end else if (fire) begin
            flags_q <= judge_flags;
            res_p   <= syn_p;
            res_n   <= syn_n;
        end
    end

    // register read view
    always_comb begin
        st_done   = (state == SQ_DONE);
        show_res  = st_done && mode_check;
        cfg_rdata = '0;
        unique case (cfg_addr)
            RA_MODE: cfg_rdata[MODE_W-1:0] = mode_bits;
            RA_CTRL: cfg_rdata[3:0] = {st_done, flags_q.multi, flags_q.ponly, flags_q.err};
            RA_PARP: cfg_rdata = REG_W'(show_res ? res_p : acc_p);
            RA_PARN: cfg_rdata = REG_W'(show_res ? res_n : acc_n);
            default: cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/nand_ecc_engine_chk.sv
module nand_ecc_engine_chk #(
    parameter int CNT_W  = 12,
    parameter int CODE_W = 16,
    parameter int REG_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [1:0]        cfg_addr,
    input logic [REG_W-1:0]  cfg_wdata,
    input logic              st_done,
    input logic [2:0]        flag_bits,
    input logic [CODE_W-1:0] acc_p,
    input logic [CODE_W-1:0] acc_n,
    input logic [CNT_W-1:0]  word_cnt,
    input logic [CNT_W-1:0]  word_lim,
    input logic              check
);

    // R1: the beat counter never leaves the selected page
    a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        word_cnt <= word_lim);

    // R3: program mode never raises a flag
    a_r3_program_clean: assert property (@(posedge clk) disable iff (!rst_n)
        !check |-> (flag_bits == 3'b000));

    // R4: verdict flags only appear once the page is complete
    a_r4_flags_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_bits != 3'b000) |-> st_done);

    // R9: a control restart clears parity, flags and done
    a_r9_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_addr == 2'd1) && cfg_wdata[0]) |=>
        (!st_done && (flag_bits == 3'b000) && (acc_p == '0) && (acc_n == '0)));

    // R10: code-error and multiple never together
    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_bits[2] && flag_bits[1]));

    // R10: a qualifying flag always comes with the error flag
    a_r10_flag_needs_err: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_bits[2] || flag_bits[1]) |-> flag_bits[0]);

    // R11: done persists without a register write
    a_r11_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_done && !cfg_we) |=> st_done);

    // R11: parity is frozen after completion
    a_r11_parity_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st_done && !cfg_we) |=> ($stable(acc_p) && $stable(acc_n)));

endmodule

bind nand_ecc_engine nand_ecc_engine_chk #(
    .CNT_W  (ADDR_W),
    .CODE_W (CODE_W),
    .REG_W  (REG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .st_done   (st_done),
    .flag_bits (flags_q),
    .acc_p     (acc_p),
    .acc_n     (acc_n),
    .word_cnt  (word_addr),
    .word_lim  (word_lim),
    .check     (mode_check)
);

// File: tb/nand_ecc_engine_test.sv
module nand_ecc_engine_test;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_strobe = 1'b0;
    logic [15:0] bus_data = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] pg [0:4095];

    nand_ecc_engine uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_strobe (bus_strobe),
        .bus_data   (bus_data),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        cfg_addr = a;
        #1 v = cfg_rdata;
    endtask

    task automatic fill(input int seed, input int nbytes);
        for (int i = 0; i < nbytes; i++)
            pg[i] = 8'((i * 37) ^ (seed * 11) ^ (i >> 3) ^ (i >> 9));
    endtask

    // bench model: per-bit position code, P on set bits, N on clear bits
    task automatic model(input int nbytes, input bit wide,
                         output logic [15:0] p, output logic [15:0] n);
        p = '0; n = '0;
        for (int i = 0; i < nbytes; i++) begin
            for (int j = 0; j < 8; j++) begin
                if (pg[i][j]) begin
                    logic [15:0] code;
                    if (wide) code = {12'(i >> 1), 4'(j + 8 * (i % 2))};
                    else      code = {12'(i), 4'(j)};
                    for (int k = 0; k < 16; k++) begin
                        if (code[k]) p[k] = ~p[k];
                        else         n[k] = ~n[k];
                    end
                end
            end
        end
    endtask

    task automatic push(input logic [15:0] w);
        @(negedge clk);
        bus_strobe = 1'b1; bus_data = w;
    endtask

    task automatic idle();
        @(negedge clk);
        bus_strobe = 1'b0; bus_data = '0;
    endtask

    // bytes [first, last) ; upper lane carries junk in byte mode
    task automatic send_range(input int first, input int last, input bit wide);
        if (wide) begin
            for (int i = first; i < last; i += 2) push({pg[i+1], pg[i]});
        end else begin
            for (int i = first; i < last; i++) push({8'(8'hA5 ^ i), pg[i]});
        end
        idle();
    endtask

    task automatic send_code(input logic [15:0] p, input logic [15:0] n, input bit wide);
        if (wide) begin
            push(p); push(n);
        end else begin
            push({8'h3C, p[7:0]}); push({8'h3C, p[15:8]});
            push({8'h3C, n[7:0]}); push({8'h3C, n[15:8]});
        end
        idle();
    endtask

    function automatic logic [15:0] mode_word(input bit chkm, input bit wide, input int sel);
        return {12'h000, chkm, wide, 2'(sel)};
    endfunction

    task automatic t_reset();
        logic [15:0] v;
        rd_reg(2'd0, v); chk("R1 mode after reset", v, 16'h0000);
        rd_reg(2'd1, v); chk("R10 status after reset", v, 16'h0000);
        rd_reg(2'd2, v); chk("R2 parity P after reset", v, 16'h0000);
    endtask

    task automatic t_program(input int sel, input bit wide, input int seed);
        logic [15:0] v, p, n;
        int nb;
        nb = 512 << sel;
        fill(seed, nb);
        model(nb, wide, p, n);
        wr_reg(2'd0, mode_word(0, wide, sel));
        rd_reg(2'd0, v); chk("R1 mode readback", v, mode_word(0, wide, sel));
        send_range(0, nb - (wide ? 2 : 1), wide);
        rd_reg(2'd1, v); chk("R3 done clear before last beat", v, 16'h0000);
        send_range(nb - (wide ? 2 : 1), nb, wide);
        rd_reg(2'd1, v); chk("R3 program status", v, 16'h0008);
        rd_reg(2'd2, v); chk("R2 program P", v, p);
        rd_reg(2'd3, v); chk("R2 program N", v, n);
    endtask

    task automatic t_ignore_after_done();
        logic [15:0] v, p, n;
        fill(5, 512);
        model(512, 0, p, n);
        wr_reg(2'd0, mode_word(0, 0, 0));
        send_range(0, 512, 0);
        for (int i = 0; i < 10; i++) push(16'h1234 + 16'(i));
        idle();
        rd_reg(2'd2, v); chk("R11 P unchanged after extra strobes", v, p);
        rd_reg(2'd3, v); chk("R11 N unchanged after extra strobes", v, n);
        rd_reg(2'd1, v); chk("R11 status unchanged after extra strobes", v, 16'h0008);
    endtask

    // check mode run: data flips in fl[], stored-code xor masks
    task automatic run_check(input int sel, input bit wide, input int seed,
                             input int f0, input int f1,
                             input logic [15:0] xp, input logic [15:0] xn,
                             input logic [15:0] exp_stat, input logic [15:0] exp_pr,
                             input string tag);
        logic [15:0] v, p, n;
        int nb;
        nb = 512 << sel;
        fill(seed, nb);
        model(nb, wide, p, n);
        if (f0 >= 0) pg[f0 >> 3][f0 % 8] = ~pg[f0 >> 3][f0 % 8];
        if (f1 >= 0) pg[f1 >> 3][f1 % 8] = ~pg[f1 >> 3][f1 % 8];
        wr_reg(2'd0, mode_word(1, wide, sel));
        send_range(0, nb, wide);
        rd_reg(2'd1, v); chk({tag, " R4 done clear before code"}, v, 16'h0000);
        send_code(p ^ xp, n ^ xn, wide);
        rd_reg(2'd1, v); chk({tag, " status"}, v, exp_stat);
        rd_reg(2'd2, v); chk({tag, " syndrome P"}, v, exp_pr);
    endtask

    task automatic t_erased();
        logic [15:0] v;
        for (int i = 0; i < 512; i++) pg[i] = 8'hFF;
        wr_reg(2'd0, mode_word(1, 0, 0));
        send_range(0, 512, 0);
        send_code(16'hFFFF, 16'hFFFF, 0);
        rd_reg(2'd1, v); chk("R8 erased status multiple", v, 16'h000D);
        rd_reg(2'd2, v); chk("R8 erased location all ones", v, 16'hFFFF);
    endtask

    task automatic t_restart();
        logic [15:0] v, p, n;
        wr_reg(2'd0, mode_word(1, 0, 0));
        for (int i = 0; i < 100; i++) push(16'(i * 7 + 3));
        idle();
        wr_reg(2'd1, 16'h0001);
        rd_reg(2'd2, v); chk("R9 parity cleared by restart", v, 16'h0000);
        rd_reg(2'd1, v); chk("R9 status cleared by restart", v, 16'h0000);
        fill(9, 512);
        model(512, 0, p, n);
        send_range(0, 512, 0);
        send_code(p, n, 0);
        rd_reg(2'd1, v); chk("R9 clean page after restart", v, 16'h0008);
    endtask

    initial begin
        #(PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_program(0, 0, 1);
        t_program(1, 1, 2);
        t_program(2, 1, 3);
        t_program(3, 0, 4);
        t_ignore_after_done();
        // R5 clean read
        run_check(0, 0, 6, -1, -1, 16'h0, 16'h0, 16'h0008, 16'h0000, "R5 clean");
        // R6 byte 300 bit 5
        run_check(0, 0, 7, 300*8 + 5, -1, 16'h0, 16'h0, 16'h0009, 16'h12C5, "R6 byte error");
        // R6 16-bit word 500 bit 13 = byte 1001 bit 5
        run_check(1, 1, 8, 1001*8 + 5, -1, 16'h0, 16'h0, 16'h0009, 16'h1F4D, "R6 word error");
        // R7 stored P bit 6 flipped
        run_check(0, 0, 10, -1, -1, 16'h0040, 16'h0, 16'h000B, 16'h0040, "R7 code error");
        // R7 stored N bit 11 flipped on 16-bit bus
        run_check(0, 1, 11, -1, -1, 16'h0, 16'h0800, 16'h000B, 16'h0000, "R7 wide code error");
        // R8 two data flips: bytes 10 bit1 and 200 bit6
        run_check(0, 0, 12, 10*8 + 1, 200*8 + 6, 16'h0, 16'h0, 16'h000D,
                  16'h00A1 ^ 16'h0C86, "R8 double error");
        t_erased();
        t_restart();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule